// File: doc/BRIEF.md
# Instruction Fetch Address Translator

This block turns an instruction-fetch virtual address into a physical address within the same cycle. It also returns a fault code that tells the fetch stage whether the fetch may go ahead. It sits between the fetch stage and a translation buffer array. It drives that array's lookup port with the virtual page number and the current address-space number, and takes back a hit flag, a frame number and a four-bit execute-enable mask.

The source of the physical address is chosen in priority order:

1. An address with bit 0 set marks privileged code and bypasses translation.
2. Otherwise, a physical-mode flag passes the address through unchanged.
3. Otherwise, a kernel-only superpage window maps a fixed region directly.
4. Otherwise, the address goes through the buffer lookup, with a per-mode execute check.

Any physical address that reaches beyond the implemented width raises a machine check.

On a fault, two registers are loaded at the next clock edge. One holds the faulting address. The other holds a page-table-entry pointer formed from a page-table base and the page number. A misspeculation input blocks that capture.

Top module: `ifetch_xlate`

## Requirements
- R1: When `req_valid` is high and `va[0]` is 1, `pa` equals `va` with bits 1:0 cleared and every bit at or above PA_W (44) cleared, and `fault` is 0 (none), whatever the other inputs are.
- R2: When `va[0]` is 0 and `phys_mode` is 1, `pa` equals `va`.
- R3: When `va[0]` and `phys_mode` are 0, `sp_en[1]` is 1 and `va[42:41]` is 2'b10, in kernel mode (`cur_mode` 0), `pa` is `va[39:0]` zero-extended and `fault` is 0.
- R4: The superpage case of R3 in any mode other than kernel (1 executive, 2 supervisor, 3 user) gives `fault` 1 (access violation).
- R5: On the translated path, an address whose bits 63:42 are neither all zero nor all one gives `fault` 1, even if the buffer reports a hit.
- R6: The lookup port carries `tlb_vpn` = `va[42:13]` and `tlb_asn` = `cur_asn`. A canonical translated fetch with `tlb_hit` 0 gives `fault` 2 (miss).
- R7: On a hit, `pa` is (`tlb_pfn` << 13) plus `va[12:2]` << 2.
- R8: On a hit whose `tlb_xen` bit at index `cur_mode` is 0, `fault` is 1.
- R9: If the physical address from R2, R3 or R7 has any bit at or above bit 44 set, and no earlier fault applies, `fault` is 3 (machine check).
- R10: At the clock edge where `req_valid` is high, `fault` is nonzero and `misspec` is 0, `ftag` loads `va` and `fform` loads `ptbr | (va[42:13] << 3)`.
- R11: While `misspec` is 1, or when there is no fault, `ftag` and `fform` keep their values.
- R12: After reset, `ftag` and `fform` are 0. While `req_valid` is 0, `fault` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A fetch translation is requested this cycle |
| va | input | 64 | Fetch virtual address |
| phys_mode | input | 1 | Use the address as physical |
| sp_en | input | 2 | Superpage enable field; bit 1 opens the window |
| cur_mode | input | 2 | Current mode: 0 kernel, 1 executive, 2 supervisor, 3 user |
| cur_asn | input | 8 | Current address-space number |
| ptbr | input | 64 | Page-table base for the formatted fault address |
| misspec | input | 1 | Fetch is misspeculated; blocks fault capture |
| tlb_vpn | output | 30 | Lookup virtual page number |
| tlb_asn | output | 8 | Lookup address-space number |
| tlb_hit | input | 1 | Lookup found a matching entry |
| tlb_pfn | input | 32 | Frame number of the matching entry |
| tlb_xen | input | 4 | Execute enable per mode of the matching entry |
| pa | output | 64 | Physical address |
| fault | output | 2 | 0 none, 1 access violation, 2 miss, 3 machine check |
| ftag | output | 64 | Captured faulting address |
| fform | output | 64 | Captured formatted page-table-entry address |

## Verification
The physical address, the fault code and the lookup port are combinational. They are due in the same cycle as the inputs that produce them. The bench drives on the falling edge and samples these outputs one nanosecond later, well before the next rising edge. The two fault registers change at the first rising edge after a qualifying fetch. The bench updates its own model of them at that edge and compares one nanosecond after it, before the next stimulus is applied.

// File: rtl/ifetch_xlate.sv
module ifetch_xlate #(
  parameter int VA_W    = 64,
  parameter int PA_W    = 44,
  parameter int VA_IMPL = 43,
  parameter int PG_W    = 13,
  parameter int PFN_W   = 32,
  parameter int ASN_W   = 8,
  parameter int SP_HI   = 39
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [VA_W-1:0]            va,
  input  logic                       phys_mode,
  input  logic [1:0]                 sp_en,
  input  logic [1:0]                 cur_mode,
  input  logic [ASN_W-1:0]           cur_asn,
  input  logic [VA_W-1:0]            ptbr,
  input  logic                       misspec,
  output logic [VA_IMPL-PG_W-1:0]    tlb_vpn,
  output logic [ASN_W-1:0]           tlb_asn,
  input  logic                       tlb_hit,
  input  logic [PFN_W-1:0]           tlb_pfn,
  input  logic [3:0]                 tlb_xen,
  output logic [VA_W-1:0]            pa,
  output logic [1:0]                 fault,
  output logic [VA_W-1:0]            ftag,
  output logic [VA_W-1:0]            fform
);
  localparam int VPN_W = VA_IMPL - PG_W;
  localparam logic [1:0] F_NONE = 2'd0, F_ACV = 2'd1, F_MISS = 2'd2, F_MCHK = 2'd3;
  localparam logic [VA_W-1:0] PA_MASK = (VA_W'(1) << PA_W) - VA_W'(1);

  logic marker, sp_win, canon;
  logic [VA_W-1:0] raw_pa, hit_pa;
  logic [1:0] pre_fault;

  assign marker  = va[0];
  assign sp_win  = sp_en[1] && (va[VA_IMPL-1:VA_IMPL-2] == 2'b10);
  assign canon   = (&va[VA_W-1:VA_IMPL-1]) || !(|va[VA_W-1:VA_IMPL-1]);
  assign tlb_vpn = va[VA_IMPL-1:PG_W];
  assign tlb_asn = cur_asn;
  assign hit_pa  = (VA_W'(tlb_pfn) << PG_W) | VA_W'({va[PG_W-1:2], 2'b00});

  always_comb begin
    raw_pa    = '0;
    pre_fault = F_NONE;
    if (phys_mode) begin
      raw_pa = va;
    end else if (sp_win) begin
      raw_pa = VA_W'(va[SP_HI:0]);
      if (cur_mode != 2'd0) pre_fault = F_ACV;
    end else if (!canon) begin
      pre_fault = F_ACV;
    end else if (!tlb_hit) begin
      pre_fault = F_MISS;
    end else begin
      raw_pa = hit_pa;
      if (!tlb_xen[cur_mode]) pre_fault = F_ACV;
    end
  end

  always_comb begin
    if (marker) begin
      pa    = va & PA_MASK & ~VA_W'(3);
      fault = F_NONE;
    end else begin
      pa    = raw_pa;
      fault = pre_fault;
      if (pre_fault == F_NONE && |(raw_pa & ~PA_MASK)) fault = F_MCHK;
    end
    if (!req_valid) fault = F_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ftag  <= '0;
      fform <= '0;
    end else if (req_valid && fault != F_NONE && !misspec) begin
      ftag  <= va;
      fform <= ptbr | (VA_W'(va[VA_IMPL-1:PG_W]) << 3);
    end
  end

  a_r1_marker_clean: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && va[0] |-> fault == F_NONE && pa[1:0] == 2'b00);
  a_r4_superpage_user: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !va[0] && !phys_mode && sp_win && cur_mode != 2'd0 |-> fault == F_ACV);
  a_r6_miss_needs_nohit: assert property (@(posedge clk) disable iff (!rst_n)
    fault == F_MISS |-> !tlb_hit);
  a_r9_pa_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && fault == F_NONE |-> (pa & ~PA_MASK) == '0);
  a_r10_capture_tag: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && fault != F_NONE && !misspec |=> ftag == $past(va));
  a_r11_hold_misspec: assert property (@(posedge clk) disable iff (!rst_n)
    misspec |=> $stable(ftag) && $stable(fform));
  a_r12_idle_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> fault == F_NONE);
endmodule

// File: tb/sim_ifetch_xlate.sv
module sim_ifetch_xlate;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, phys_mode = 0, misspec = 0, tlb_hit = 0;
  logic [63:0] va = 0, ptbr = 0;
  logic [1:0] sp_en = 0, cur_mode = 0;
  logic [7:0] cur_asn = 0;
  logic [31:0] tlb_pfn = 0;
  logic [3:0] tlb_xen = 0;
  logic [29:0] tlb_vpn;
  logic [7:0] tlb_asn;
  logic [63:0] pa, ftag, fform;
  logic [1:0] fault;
  logic [63:0] mtag = 0, mform = 0;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ifetch_xlate u0 (.clk, .rst_n, .req_valid, .va, .phys_mode, .sp_en, .cur_mode,
    .cur_asn, .ptbr, .misspec, .tlb_vpn, .tlb_asn, .tlb_hit, .tlb_pfn, .tlb_xen,
    .pa, .fault, .ftag, .fform);

  localparam logic [63:0] MASK = 64'h0000_0FFF_FFFF_FFFF;

  function automatic logic [63:0] ref_raw();
    if (va[0]) return va & MASK & ~64'd3;
    if (phys_mode) return va;
    if (sp_en[1] && va[42:41] == 2'b10) return {24'd0, va[39:0]};
    if (tlb_hit) return ({32'd0, tlb_pfn} << 13) + {51'd0, va[12:2], 2'b00};
    return 64'd0;
  endfunction

  function automatic logic [1:0] ref_fault();
    logic [63:0] p;
    if (!req_valid || va[0]) return 2'd0;
    p = ref_raw();
    if (!phys_mode) begin
      if (sp_en[1] && va[42:41] == 2'b10) begin
        if (cur_mode != 0) return 2'd1;
      end else begin
        if ((va >> 42) != 0 && (va >> 42) != 64'h3F_FFFF) return 2'd1;
        if (!tlb_hit) return 2'd2;
        if (!tlb_xen[cur_mode]) return 2'd1;
      end
    end
    if ((p >> 44) != 0) return 2'd3;
    return 2'd0;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(string tag);
    logic [1:0] ef;
    #1;
    ef = ref_fault();
    chk({tag, " fault"}, 64'(fault), 64'(ef));
    if (req_valid && (va[0] || ef == 2'd0 || ef == 2'd3)) chk({tag, " pa"}, pa, ref_raw());
    chk("R6 vpn", 64'(tlb_vpn), 64'(va[42:13]));
    chk("R6 asn", 64'(tlb_asn), 64'(cur_asn));
    if (req_valid && ef != 0 && !misspec) begin
      mtag = va;
      mform = ptbr | ({34'd0, va[42:13]} << 3);
    end
    @(posedge clk); #1;
    chk("R10/R11 ftag", ftag, mtag);
    chk("R10/R11 fform", fform, mform);
    @(negedge clk);
  endtask

  function automatic logic [63:0] canon_va(logic [63:0] r);
    return r[42] ? (r | ~64'h7FF_FFFF_FFFF) : (r & 64'h7FF_FFFF_FFFF);
  endfunction

  initial begin
    #4000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    chk("R12 reset ftag", ftag, 64'd0);
    chk("R12 reset fform", fform, 64'd0);
    @(negedge clk); @(negedge clk); rst_n = 1; @(negedge clk);
    ptbr = 64'h0000_0200_0000_0000; cur_asn = 8'h5A;
    // R12 idle
    va = 64'h1234_5678; req_valid = 0; step("R12");
    req_valid = 1;
    // R1 marker
    va = 64'hFFFF_FFFF_FFFF_FFFF; cur_mode = 3; tlb_hit = 0; step("R1");
    chk("R1 pa value", pa, 64'h0000_0FFF_FFFF_FFFC);
    // R2 phys mode
    va = 64'h0000_0012_3456_7890; va[0] = 0; phys_mode = 1; step("R2");
    chk("R2 pa value", pa, 64'h0000_0012_3456_7890);
    // R9 phys out of range
    va = 64'h0004_0000_0000_0000; step("R9");
    chk("R9 mcheck", 64'(fault), 64'd3);
    phys_mode = 0;
    // R3 superpage kernel
    sp_en = 2'b10; cur_mode = 0; va = 64'h0000_0412_3456_7894; step("R3");
    chk("R3 pa value", pa, 64'h0000_0012_3456_7894);
    // R4 superpage user
    cur_mode = 3; step("R4");
    chk("R4 acv", 64'(fault), 64'd1);
    sp_en = 2'b01;
    // R5 non-canonical with hit
    cur_mode = 0; tlb_hit = 1; tlb_xen = 4'hF; tlb_pfn = 32'h10;
    va = 64'h0001_0000_0000_2000; step("R5");
    chk("R5 acv", 64'(fault), 64'd1);
    // R6 miss
    tlb_hit = 0; va = 64'hFFFF_FFFF_FFFF_E008; step("R6");
    chk("R6 miss", 64'(fault), 64'd2);
    // R7 hit
    tlb_hit = 1; tlb_pfn = 32'h0000_1234; va = 64'h0000_0000_0000_3FFE; step("R7");
    chk("R7 pa value", pa, 64'h0000_0000_0246_9FFC);
    // R8 execute denied for supervisor
    cur_mode = 2; tlb_xen = 4'b1011; step("R8");
    chk("R8 acv", 64'(fault), 64'd1);
    // R9 hit beyond width
    cur_mode = 0; tlb_pfn = 32'h8000_0000; step("R9");
    chk("R9 hit mcheck", 64'(fault), 64'd3);
    // R11 misspec blocks capture
    misspec = 1; tlb_hit = 0; va = 64'h0000_0000_00AB_C000; step("R11");
    misspec = 0;
    // R11 no fault no capture
    tlb_hit = 1; tlb_pfn = 32'h7; step("R11");
    // random
    for (int i = 0; i < 600; i++) begin
      logic [63:0] r;
      int cls;
      r = {$urandom, $urandom};
      cls = $urandom_range(0, 5);
      case (cls)
        0: va = r | 64'd1;
        1: va = r & ~64'd1;
        2: begin va = canon_va(r) & ~64'd1; va[42:41] = 2'b10; end
        default: va = canon_va(r) & ~64'd1;
      endcase
      req_valid = ($urandom_range(0, 9) != 0);
      phys_mode = ($urandom_range(0, 5) == 0);
      sp_en = 2'($urandom);
      cur_mode = 2'($urandom);
      cur_asn = 8'($urandom);
      ptbr = {$urandom, $urandom} & ~64'h7;
      misspec = ($urandom_range(0, 4) == 0);
      tlb_hit = ($urandom_range(0, 3) != 0);
      tlb_pfn = $urandom & ($urandom_range(0, 7) == 0 ? 32'hFFFF_FFFF : 32'h7FFF_FFFF);
      tlb_xen = 4'($urandom);
      step("R1-random R7");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule